// File: doc/BRIEF.md
# Buffered Input Capture Group

This block timestamps edges on a set of input pins. A free-running main timer is copied into a channel's capture register whenever a selected edge arrives on that channel's pin. Each channel also has an 8-bit pulse accumulator that counts the same selected edges. Each channel has two holding registers: one paired with the capture register and one paired with the accumulator. Together with the capture register, this gives every channel a two-deep history of edge times.

The holding registers have two modes of operation, chosen by a mode bit. In queue mode, every capture shifts the previous capture time into the holding register, so software can measure the time between the last two edges. In latch mode, edges touch only the capture register and accumulator. All channels are then snapshotted together into their holding registers on a latch event, and the accumulators restart from zero. A latch event comes from a modulus down-counter running out, from software loading zero into that counter, or from a forced-latch command. A simple registered read/write port gives software access to the control fields and the values.

Top module: `buffered_capture`

## Requirements
- R1: After a synchronous reset, the following all read 0: control (address 0x00: bit0 buffer enable, bit1 latch mode, bit2 force latch), edge select (0x01), every capture register (0x10+ch), every holding register (0x18+ch) and every accumulator (0x20+ch).
- R2: In queue mode (bit1=0) with buffering enabled (bit0=1), a selected edge stores the timer in the capture register and moves the old capture value into the holding register in the same cycle.
- R3: With buffering disabled (bit0=0), edges still update the capture register and accumulators. The holding registers never change, including on a force command or a modulus zero.
- R4: In latch mode (bit1=1) with buffering enabled, an edge updates only the capture register and accumulator. The holding registers keep their values.
- R5: Writing the control register with bits 0, 1 and 2 all set produces an immediate latch event.
- R6: Bit 2 of the control register is self-clearing and always reads back 0.
- R7: A latch event copies every capture register and every accumulator (0x20+ch) into its holding register (0x18+ch and 0x28+ch) in one cycle, and then clears every accumulator.
- R8: Writing 0 to the modulus counter (address 0x02) while in latch mode with buffering enabled produces a latch event.
- R9: The modulus counter decrements once per clock while nonzero and reads back its current count. The clock in which it steps from 1 to 0 produces a latch event when in latch mode with buffering enabled.
- R10: The edge-select register (0x01) holds a 2-bit field per channel at bits [2ch+1:2ch]: 00 ignores the pin, 01 selects rising, 10 selects falling, 11 selects both edges. The field governs both capture and accumulation. A capture holds the timer value from 2 clocks after the pin change, because of the two-flop synchronizer.
- R11: An accumulator counts selected edges and stays at 0xFF instead of wrapping.
- R12: If an edge and a latch event fall in the same cycle, the holding registers receive the pre-edge capture and accumulator values. The capture register takes the new timer value, and the accumulator restarts at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | NCH | Asynchronous capture pins |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register write address |
| wr_data | input | TW | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 6 | Register read address |
| rd_data | output | TW | Read data, one clock after rd_en |
| rd_valid | output | 1 | Marks rd_data as valid |

## Verification
A wrong shift or snapshot decision appears as a wrong holding-register value on the very next read after the edge or latch event. It is never self-correcting, because the holding registers change only on those events. Accumulator faults (missed clear, wrap instead of saturation) stay visible until the next snapshot. Capture timing errors appear as a fixed offset between the capture register and the edge time computed by the bench. Collision ordering shows up when an edge and a forced latch are made to coincide.

// File: rtl/cap_pkg.sv
package cap_pkg;
  localparam int AW = 6;
  localparam logic [AW-1:0] A_CTRL = 6'h00;
  localparam logic [AW-1:0] A_EDGE = 6'h01;
  localparam logic [AW-1:0] A_MOD  = 6'h02;
  localparam logic [AW-1:0] A_TIME = 6'h03;
  localparam logic [2:0] G_MISC = 3'd0;
  localparam logic [2:0] G_CAP  = 3'd2;
  localparam logic [2:0] G_HOLD = 3'd3;
  localparam logic [2:0] G_ACC  = 3'd4;
  localparam logic [2:0] G_ACCH = 3'd5;
  typedef enum logic [1:0] {
    EDG_OFF  = 2'b00,
    EDG_RISE = 2'b01,
    EDG_FALL = 2'b10,
    EDG_ANY  = 2'b11
  } edge_sel_e;
endpackage

// File: rtl/cap_edge_det.sv
module cap_edge_det
  import cap_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       pin,
  input  logic [1:0] sel,
  output logic       hit
);
  logic s1, s2, s3;
  logic rise, fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= pin;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign rise = s2 & ~s3;
  assign fall = ~s2 & s3;
  assign hit  = ((sel == EDG_RISE || sel == EDG_ANY) && rise) ||
                ((sel == EDG_FALL || sel == EDG_ANY) && fall);
endmodule

// File: rtl/cap_chan.sv
module cap_chan #(
  parameter int TW = 16,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hit,
  input  logic          buf_en,
  input  logic          latch_mode,
  input  logic          lev,
  input  logic [TW-1:0] timer,
  output logic [TW-1:0] cap,
  output logic [TW-1:0] hold,
  output logic [PW-1:0] pacc,
  output logic [PW-1:0] pacc_hold
);
  localparam logic [PW-1:0] PMAX = '1;
  localparam logic [PW-1:0] PONE = PW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cap       <= '0;
      hold      <= '0;
      pacc      <= '0;
      pacc_hold <= '0;
    end else begin
      if (lev) begin
        hold      <= cap;
        pacc_hold <= pacc;
        pacc      <= hit ? PONE : '0;
      end else if (hit && pacc != PMAX) begin
        pacc <= pacc + PONE;
      end
      if (hit) begin
        cap <= timer;
        if (buf_en && !latch_mode) hold <= cap;
      end
    end
  end

  a_r2_queue_shift: assert property (@(posedge clk) disable iff (rst)
    (hit && buf_en && !latch_mode) |=> (hold == $past(cap)));
  a_r4_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (!lev && !(hit && buf_en && !latch_mode)) |=> $stable(hold));
  a_r7_acc_cleared: assert property (@(posedge clk) disable iff (rst)
    lev |=> (pacc <= PONE));
  a_r11_acc_saturates: assert property (@(posedge clk) disable iff (rst)
    (pacc == PMAX && !lev) |=> (pacc == PMAX));
  a_r12_pre_edge_copy: assert property (@(posedge clk) disable iff (rst)
    (lev && hit) |=> (hold == $past(cap) && cap == $past(timer)));
endmodule

// File: rtl/cap_modcnt.sv
module cap_modcnt #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld,
  input  logic [TW-1:0] ld_val,
  output logic [TW-1:0] cnt,
  output logic          zero_evt
);
  localparam logic [TW-1:0] ONE = TW'(1);

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (ld)         cnt <= ld_val;
    else if (cnt != '0)  cnt <= cnt - ONE;
  end

  assign zero_evt = ld ? (ld_val == '0) : (cnt == ONE);

  a_r9_count_down: assert property (@(posedge clk) disable iff (rst)
    (!ld && cnt != '0) |=> (cnt == $past(cnt) - ONE));
endmodule

// File: rtl/buffered_capture.sv
module buffered_capture
  import cap_pkg::*;
#(
  parameter int NCH = 4,
  parameter int TW  = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] pin_in,
  input  logic           wr_en,
  input  logic [5:0]     wr_addr,
  input  logic [TW-1:0]  wr_data,
  input  logic           rd_en,
  input  logic [5:0]     rd_addr,
  output logic [TW-1:0]  rd_data,
  output logic           rd_valid
);
  localparam int PW = 8;
  localparam int EW = 2 * NCH;
  localparam logic [TW-1:0] TONE = TW'(1);

  logic          buf_en, latch_mode;
  logic [EW-1:0] edge_sel;
  logic [TW-1:0] timer_q;
  logic [TW-1:0] mod_cnt;
  logic          mod_zero, wr_ctrl, wr_mod, force_req, lev;
  logic [TW-1:0] rd_mux;

  logic [NCH-1:0] hit;
  logic [TW-1:0]  cap_a  [NCH];
  logic [TW-1:0]  hold_a [NCH];
  logic [PW-1:0]  acc_a  [NCH];
  logic [PW-1:0]  acch_a [NCH];

  assign wr_ctrl   = wr_en && (wr_addr == A_CTRL);
  assign wr_mod    = wr_en && (wr_addr == A_MOD);
  assign force_req = wr_ctrl && (wr_data[2:0] == 3'b111);
  assign lev       = force_req || (mod_zero && buf_en && latch_mode);

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_en     <= 1'b0;
      latch_mode <= 1'b0;
      edge_sel   <= '0;
      timer_q    <= '0;
    end else begin
      timer_q <= timer_q + TONE;
      if (wr_ctrl) begin
        buf_en     <= wr_data[0];
        latch_mode <= wr_data[1];
      end
      if (wr_en && wr_addr == A_EDGE) edge_sel <= wr_data[EW-1:0];
    end
  end

  cap_modcnt #(.TW(TW)) u_mod (
    .clk(clk), .rst(rst), .ld(wr_mod), .ld_val(wr_data),
    .cnt(mod_cnt), .zero_evt(mod_zero)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    cap_edge_det u_det (
      .clk(clk), .rst(rst), .pin(pin_in[g]),
      .sel(edge_sel[2*g +: 2]), .hit(hit[g])
    );
    cap_chan #(.TW(TW), .PW(PW)) u_chan (
      .clk(clk), .rst(rst), .hit(hit[g]), .buf_en(buf_en),
      .latch_mode(latch_mode), .lev(lev), .timer(timer_q),
      .cap(cap_a[g]), .hold(hold_a[g]), .pacc(acc_a[g]), .pacc_hold(acch_a[g])
    );
  end

  always_comb begin
    rd_mux = '0;
    if (rd_addr[5:3] == G_MISC) begin
      case (rd_addr)
        A_CTRL:  rd_mux = {{(TW-2){1'b0}}, latch_mode, buf_en};
        A_EDGE:  rd_mux = TW'(edge_sel);
        A_MOD:   rd_mux = mod_cnt;
        A_TIME:  rd_mux = timer_q;
        default: rd_mux = '0;
      endcase
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (rd_addr[2:0] == i[2:0]) begin
          case (rd_addr[5:3])
            G_CAP:   rd_mux = cap_a[i];
            G_HOLD:  rd_mux = hold_a[i];
            G_ACC:   rd_mux = TW'(acc_a[i]);
            G_ACCH:  rd_mux = TW'(acch_a[i]);
            default: rd_mux = '0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_mux;
    end
  end

  a_r6_force_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr == A_CTRL) |=> (rd_data[2] == 1'b0));
  a_r5_force_latches: assert property (@(posedge clk) disable iff (rst)
    force_req |=> (hold_a[0] == $past(cap_a[0]) && acc_a[0] <= PW'(1)));
endmodule

// File: tb/sim_buffered_capture.sv
`timescale 1ns/1ps
module sim_buffered_capture;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  pins = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [5:0]  wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        rd_valid;
  logic [15:0] tb_t;
  int n_vec = 0, n_bad = 0;
  bit done = 0;

  typedef struct { logic [15:0] exp; string tag; } item_t;
  item_t sb_q[$];

  always #2.5 clk = ~clk;

  buffered_capture u0 (
    .clk(clk), .rst(rst), .pin_in(pins), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  always @(posedge clk) begin
    if (rst) tb_t <= '0;
    else     tb_t <= tb_t + 16'd1;
  end

  always @(negedge clk) begin
    if (rd_valid) begin
      item_t it;
      it = sb_q.pop_front();
      n_vec++;
      if (rd_data !== it.exp) begin
        n_bad++;
        $display("FAIL %s: actual=%h expected=%h", it.tag, rd_data, it.exp);
      end
    end
  end

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [15:0] e, input string t);
    item_t it;
    it.exp = e; it.tag = t;
    @(negedge clk); rd_en = 1'b1; rd_addr = a; sb_q.push_back(it);
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic pin(input int ch, input logic lvl, output logic [15:0] c);
    @(negedge clk); pins[ch] = lvl; c = tb_t + 16'd2;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    logic [15:0] c1, c2, c3, c4, c5, c6, c7, c8, c9, d1, junk;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd(6'h00, 16'h0000, "R1 ctrl");
    rd(6'h01, 16'h0000, "R1 edge");
    rd(6'h10, 16'h0000, "R1 cap0");
    rd(6'h18, 16'h0000, "R1 hold0");
    rd(6'h20, 16'h0000, "R1 acc0");
    // R10 field 00 ignores the pin
    pin(0, 1'b1, junk);
    rd(6'h10, 16'h0000, "R10 off no capture");
    rd(6'h20, 16'h0000, "R10 off no count");
    pin(0, 1'b0, junk);
    wr(6'h01, 16'h0055);
    // R3 buffering off, queue mode
    pin(0, 1'b1, c1);
    rd(6'h10, c1, "R3 cap0 updates");
    rd(6'h18, 16'h0000, "R3 hold0 untouched");
    pin(0, 1'b0, junk);
    rd(6'h10, c1, "R10 falling ignored in rise mode");
    // R2 queue shift
    wr(6'h00, 16'h0001);
    pin(0, 1'b1, c2);
    rd(6'h10, c2, "R2 cap0 first");
    rd(6'h18, c1, "R2 hold0 first");
    pin(0, 1'b0, junk);
    pin(0, 1'b1, c3);
    rd(6'h10, c3, "R2 cap0 second");
    rd(6'h18, c2, "R2 hold0 second");
    rd(6'h20, 16'd3, "R10 rising count");
    // R4 latch mode
    wr(6'h00, 16'h0003);
    pin(0, 1'b0, junk);
    pin(0, 1'b1, c4);
    pin(1, 1'b1, d1);
    rd(6'h10, c4, "R4 cap0");
    rd(6'h18, c2, "R4 hold0 kept");
    rd(6'h19, 16'h0000, "R4 hold1 kept");
    // R5 / R7 forced latch
    wr(6'h00, 16'h0007);
    rd(6'h18, c4, "R5 hold0");
    rd(6'h19, d1, "R7 hold1");
    rd(6'h28, 16'd4, "R7 acc hold0");
    rd(6'h29, 16'd1, "R7 acc hold1");
    rd(6'h20, 16'd0, "R7 acc0 cleared");
    rd(6'h21, 16'd0, "R7 acc1 cleared");
    rd(6'h00, 16'h0003, "R6 force reads 0");
    // R3 force ignored with buffering off
    pin(0, 1'b0, junk);
    pin(0, 1'b1, c5);
    wr(6'h00, 16'h0006);
    rd(6'h18, c4, "R3 hold0 no force");
    rd(6'h28, 16'd4, "R3 acc hold0 no force");
    rd(6'h20, 16'd1, "R3 acc0 not cleared");
    rd(6'h00, 16'h0002, "R6 ctrl after force");
    // R8 write zero to modulus
    wr(6'h00, 16'h0003);
    wr(6'h02, 16'h0000);
    rd(6'h18, c5, "R8 hold0");
    rd(6'h28, 16'd1, "R8 acc hold0");
    rd(6'h20, 16'd0, "R8 acc0 cleared");
    // R9 countdown to zero
    pin(0, 1'b0, junk);
    pin(0, 1'b1, c6);
    wr(6'h02, 16'd6);
    repeat (12) @(negedge clk);
    rd(6'h02, 16'd0, "R9 count at zero");
    rd(6'h18, c6, "R9 hold0");
    rd(6'h28, 16'd1, "R9 acc hold0");
    // R10 falling, then both edges
    wr(6'h01, 16'h0056);
    pin(0, 1'b0, c7);
    rd(6'h10, c7, "R10 falling capture");
    wr(6'h01, 16'h0057);
    pin(0, 1'b1, c8);
    rd(6'h10, c8, "R10 both capture");
    rd(6'h20, 16'd2, "R10 both count");
    // R12 edge and forced latch in the same cycle
    @(negedge clk); pins[0] = 1'b0; c9 = tb_t + 16'd2;
    @(negedge clk);
    @(negedge clk); wr_en = 1'b1; wr_addr = 6'h00; wr_data = 16'h0007;
    @(negedge clk); wr_en = 1'b0;
    repeat (3) @(negedge clk);
    rd(6'h18, c8, "R12 hold0 pre-edge");
    rd(6'h10, c9, "R12 cap0 new");
    rd(6'h28, 16'd2, "R12 acc hold0 pre-edge");
    rd(6'h20, 16'd1, "R12 acc0 restarts");
    // R11 saturation
    for (int k = 0; k < 260; k++) begin
      @(negedge clk); pins[1] = 1'b1;
      repeat (2) @(negedge clk); pins[1] = 1'b0;
      repeat (2) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    rd(6'h21, 16'h00FF, "R11 acc1 saturated");
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule